// File: doc/BRIEF.md
# Shift-Redundancy Via Router

This block carries a group of logical vertical signals across a stack boundary on a slightly larger group of through-silicon vias. Two of the vias are spares. Each logical signal can be switched only onto a short run of neighbouring vias: signal `i` may use via `i` up to via `i+SW-1`. A broken via is therefore bypassed by shifting the signals above it upward inside their windows, not by a full crossbar.

A fault map, one bit per via (1 = broken), is captured when `load` is pulsed. A sequential solver then settles one signal per clock. Each signal takes the lowest healthy via in its window that lies above the via picked for the signal before it. If every signal finds a via, the new selects are committed. If not, the attempt is reported as failed and the previous routing stays in force. The same select values steer the transmit fan-out onto the vias and the receive gather back into logical order. A die pair that shares one fault map therefore agrees on the routing.

Top module: `tsv_shift_router`

## Requirements
- R1: After reset every select is 0, so signal `i` rides via `i`; `repair_done` and `repair_ok` are 0, and vias `N_SIG` up to `N_VIA-1` are driven 0.
- R2: A load with an all-clear fault map commits all-zero selects and sets `repair_ok` to 1.
- R3: A committed select `s` for signal `i` names via `i+s`, with `0 <= s <= SW-1` and `i+s <= N_VIA-1`. The committed via is healthy in the captured map.
- R4: Signals are assigned in ascending order. Each signal takes the lowest healthy via in its window that is strictly above the via of the previous signal.
- R5: If some signal has no usable via, `repair_ok` reads 0 after the done pulse and the committed selects keep their earlier values.
- R6: `repair_done` is a one-cycle pulse. Take the clock edge that samples `load` high as edge 0. The pulse follows edge `N_SIG` on success, or edge `k+1` when signal `k` is the first to fail.
- R7: While a solve is in progress the committed selects do not change, and a `load` pulse arriving during the solve is ignored.
- R8: On the transmit side, via `i+s` carries `tx_data[i]` for every signal `i` with select `s`. Every via used by no signal, including every via marked broken in the committed map, is driven 0.
- R9: On the receive side, `rx_data[i]` equals `via_in[i+s]`, where `s` is the select of signal `i`.
- R10: `cfg_sel` packs the select of signal `i` at bits `[i*SEL_W +: SEL_W]`, with `SEL_W = clog2(SW)`. This gives 2 bits per signal for the default `SW=3`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture `fault_map` and start a solve |
| fault_map | input | N_VIA | Broken-via map, 1 = broken |
| tx_data | input | N_SIG | Logical signals to transmit |
| via_out | output | N_VIA | Drive onto the physical vias |
| via_in | input | N_VIA | Values received from the physical vias |
| rx_data | output | N_SIG | Recovered logical signals |
| repair_done | output | 1 | One-cycle pulse at the end of a solve |
| repair_ok | output | 1 | Result of the last solve, 1 = committed |
| cfg_sel | output | N_SIG*SEL_W | Committed per-signal via offsets |

## Verification
The solver is loaded with several fault maps, and each one tells a different behaviour apart. A clear map gives the identity routing. A break on the lowest via shifts every signal by one. Two scattered breaks produce mixed offsets and test the rule that each via lies strictly above the previous one. Breaks at the top vias should leave the routing untouched. Three adjacent breaks, placed once in the middle and once at via 0, must fail, and the two placements give different done latencies. A second load arriving during a solve must not alter the result. For each committed routing, several data words are sent through a loopback in which broken vias are forced high. This exposes any signal routed onto a broken via and any broken via that is not held low.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} solve_state_t;

  function automatic int sel_bits(input int sw);
    return (sw <= 1) ? 1 : $clog2(sw);
  endfunction
endpackage

// File: rtl/tsv_repair_solver.sv
module tsv_repair_solver
  import tsv_pkg::*;
#(
  parameter int N_SIG = 8,
  parameter int N_VIA = 10,
  parameter int SW    = 3,
  parameter int SEL_W = 2,
  parameter int IDX_W = 3,
  parameter int VIA_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_i,
  input  logic [N_VIA-1:0]             fault_i,
  output logic [N_SIG-1:0][SEL_W-1:0]  cfg_o,
  output logic [N_VIA-1:0]             map_o,
  output logic                         done_o,
  output logic                         ok_o,
  output logic                         busy_o,
  output logic                         step_hit_o,
  output logic [VIA_W-1:0]             step_via_o
);
  localparam int LAST = N_SIG - 1;

  solve_state_t             state_q;
  logic [IDX_W-1:0]         idx_q;
  logic [VIA_W:0]           floor_q;
  logic [N_VIA-1:0]         flt_q;
  logic [N_SIG-1:0][SEL_W-1:0] work_q, work_nx;
  logic [SEL_W-1:0]         step_sel;

  // lowest healthy via in the window of signal idx, at or above floor
  function automatic logic [VIA_W:0] pick_via(input logic [N_VIA-1:0] flt,
                                              input int idx, input int flo);
    logic found;
    logic [VIA_W-1:0] via;
    found = 1'b0;
    via   = '0;
    for (int v = 0; v < N_VIA; v++) begin
      if (!found && v >= idx && v >= flo && v <= idx + SW - 1 && !flt[v]) begin
        found = 1'b1;
        via   = VIA_W'(v);
      end
    end
    return {found, via};
  endfunction

  logic [VIA_W:0] pick;
  assign pick       = pick_via(flt_q, int'(idx_q), int'(floor_q));
  assign step_hit_o = pick[VIA_W];
  assign step_via_o = pick[VIA_W-1:0];
  assign step_sel   = SEL_W'(int'(step_via_o) - int'(idx_q));
  assign busy_o     = (state_q == ST_RUN);

  always_comb begin
    work_nx        = work_q;
    work_nx[idx_q] = step_sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      floor_q <= '0;
      flt_q   <= '0;
      work_q  <= '0;
      cfg_o   <= '0;
      map_o   <= '0;
      done_o  <= 1'b0;
      ok_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (load_i) begin
            state_q <= ST_RUN;
            idx_q   <= '0;
            floor_q <= '0;
            flt_q   <= fault_i;
          end
        end
        ST_RUN: begin
          if (step_hit_o) begin
            work_q  <= work_nx;
            floor_q <= (VIA_W+1)'(int'(step_via_o) + 1);
            if (int'(idx_q) == LAST) begin
              cfg_o   <= work_nx;
              map_o   <= flt_q;
              done_o  <= 1'b1;
              ok_o    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            done_o  <= 1'b1;
            ok_o    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && ok_o) |-> $stable(cfg_o));

  p_map_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && ok_o) |-> $stable(map_o));

  p_step_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && step_hit_o) |-> (int'(step_via_o) >= int'(idx_q) &&
      int'(step_via_o) <= int'(idx_q) + SW - 1 && !flt_q[step_via_o]));

  p_step_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && step_hit_o) |-> (int'(step_via_o) >= int'(floor_q)));
endmodule

// File: rtl/tsv_tx_route.sv
module tsv_tx_route #(
  parameter int N_SIG = 8,
  parameter int N_VIA = 10,
  parameter int SW    = 3,
  parameter int SEL_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_SIG-1:0]             data_i,
  input  logic [N_SIG-1:0][SEL_W-1:0]  cfg_i,
  input  logic [N_VIA-1:0]             map_i,
  output logic [N_VIA-1:0]             via_o
);
  for (genvar v = 0; v < N_VIA; v++) begin : g_via
    always_comb begin
      via_o[v] = 1'b0;
      for (int i = 0; i < N_SIG; i++) begin
        if (v >= i && v <= i + SW - 1 && (i + int'(cfg_i[i])) == v)
          via_o[v] = data_i[i];
      end
    end
  end

  p_fault_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (via_o & map_i) == '0);
endmodule

// File: rtl/tsv_rx_route.sv
module tsv_rx_route #(
  parameter int N_SIG = 8,
  parameter int N_VIA = 10,
  parameter int SEL_W = 2
) (
  input  logic [N_VIA-1:0]             via_i,
  input  logic [N_SIG-1:0][SEL_W-1:0]  cfg_i,
  output logic [N_SIG-1:0]             data_o
);
  for (genvar i = 0; i < N_SIG; i++) begin : g_sig
    always_comb begin
      data_o[i] = 1'b0;
      for (int v = 0; v < N_VIA; v++) begin
        if ((i + int'(cfg_i[i])) == v) data_o[i] = via_i[v];
      end
    end
  end
endmodule

// File: rtl/tsv_shift_router.sv
module tsv_shift_router
  import tsv_pkg::*;
#(
  parameter int N_SIG = 8,
  parameter int N_VIA = 10,
  parameter int SW    = 3,
  localparam int SEL_W = sel_bits(SW),
  localparam int IDX_W = (N_SIG <= 1) ? 1 : $clog2(N_SIG),
  localparam int VIA_W = (N_VIA <= 1) ? 1 : $clog2(N_VIA)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [N_VIA-1:0]         fault_map,
  input  logic [N_SIG-1:0]         tx_data,
  output logic [N_VIA-1:0]         via_out,
  input  logic [N_VIA-1:0]         via_in,
  output logic [N_SIG-1:0]         rx_data,
  output logic                     repair_done,
  output logic                     repair_ok,
  output logic [N_SIG*SEL_W-1:0]   cfg_sel
);
  logic [N_SIG-1:0][SEL_W-1:0] cfg_w;
  logic [N_VIA-1:0]            map_w;
  logic                        busy_w, hit_w;
  logic [VIA_W-1:0]            via_w;

  tsv_repair_solver #(.N_SIG(N_SIG), .N_VIA(N_VIA), .SW(SW), .SEL_W(SEL_W),
                      .IDX_W(IDX_W), .VIA_W(VIA_W)) u_solver (
    .clk(clk), .rst_n(rst_n), .load_i(load), .fault_i(fault_map),
    .cfg_o(cfg_w), .map_o(map_w), .done_o(repair_done), .ok_o(repair_ok),
    .busy_o(busy_w), .step_hit_o(hit_w), .step_via_o(via_w));

  tsv_tx_route #(.N_SIG(N_SIG), .N_VIA(N_VIA), .SW(SW), .SEL_W(SEL_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .data_i(tx_data), .cfg_i(cfg_w), .map_i(map_w),
    .via_o(via_out));

  tsv_rx_route #(.N_SIG(N_SIG), .N_VIA(N_VIA), .SEL_W(SEL_W)) u_rx (
    .via_i(via_in), .cfg_i(cfg_w), .data_o(rx_data));

  assign cfg_sel = cfg_w;

  // committed routing is legal: offsets in window, vias strictly ascending
  function automatic logic cfg_legal(input logic [N_SIG-1:0][SEL_W-1:0] c);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < N_SIG; i++) begin
      if (int'(c[i]) > SW - 1 || i + int'(c[i]) > N_VIA - 1) ok = 1'b0;
      if (i > 0 && (i + int'(c[i])) <= (i - 1 + int'(c[i-1]))) ok = 1'b0;
    end
    return ok;
  endfunction

  p_cfg_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_legal(cfg_w));

  p_load_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && load) |=> (busy_w || repair_done));

  p_tx_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(via_out) == $countones(tx_data));
endmodule

// File: tb/tsv_shift_router_tb.sv
module tsv_shift_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int V  = 10;
  localparam int SW = 3;
  localparam int SB = 2;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0;
  logic [V-1:0] fault_map = '0, via_in;
  logic [N-1:0] tx_data = '0, rx_data;
  logic [V-1:0] via_out;
  logic repair_done, repair_ok;
  logic [N*SB-1:0] cfg_sel;

  int checks = 0, errors = 0;
  logic [N*SB-1:0] exp_cfg = '0;
  logic [V-1:0]    exp_map = '0;
  logic            loop_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // loopback with broken vias forced high
  assign via_in = loop_on ? (via_out | exp_map) : '0;

  tsv_shift_router #(.N_SIG(N), .N_VIA(V), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .fault_map(fault_map),
    .tx_data(tx_data), .via_out(via_out), .via_in(via_in), .rx_data(rx_data),
    .repair_done(repair_done), .repair_ok(repair_ok), .cfg_sel(cfg_sel));

  task automatic check(input logic cond, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model: scan offsets per signal, keep strictly rising via
  task automatic model(input logic [V-1:0] f, output logic [N*SB-1:0] c,
                       output logic ok, output int fail_at);
    int last;
    last = -1; ok = 1'b1; fail_at = -1; c = '0;
    for (int i = 0; i < N; i++) begin
      int got;
      got = -1;
      for (int s = 0; s < SW; s++)
        if (got < 0 && i + s < V && i + s > last && !f[i+s]) got = s;
      if (got < 0) begin
        if (ok) fail_at = i;
        ok = 1'b0;
      end else begin
        c[i*SB +: SB] = SB'(got);
        last = i + got;
      end
    end
  endtask

  function automatic logic [V-1:0] tx_expect(input logic [N-1:0] d,
                                             input logic [N*SB-1:0] c);
    logic [V-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) r[i + int'(c[i*SB +: SB])] = d[i];
    return r;
  endfunction

  // load a map, optionally pulse load again mid-solve, check latency and result
  task automatic run_solve(input logic [V-1:0] f, input string tag,
                           input logic [V-1:0] late_map, input logic late);
    logic [N*SB-1:0] mc;
    logic mok;
    int fk, lat, exp_lat, pulses;
    model(f, mc, mok, fk);
    exp_lat = mok ? N : fk + 1;
    fault_map = f; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    lat = -1; pulses = 0;
    for (int t = 1; t <= N + 4; t++) begin
      if (late && t == 2) begin fault_map = late_map; load = 1'b1; end
      @(negedge clk);
      if (late && t == 2) load = 1'b0;
      if (repair_done) begin
        pulses++;
        if (lat < 0) lat = t;
      end
      if (lat < 0) check(cfg_sel == exp_cfg, {tag, " R7 hold"}, cfg_sel, exp_cfg);
    end
    check(lat == exp_lat, {tag, " R6 latency"}, lat, exp_lat);
    check(pulses == 1, {tag, " R6 single pulse"}, pulses, 1);
    check(repair_ok == mok, {tag, " R5 ok flag"}, repair_ok, mok);
    if (mok) begin exp_cfg = mc; exp_map = f; end
    check(cfg_sel == exp_cfg, {tag, " R3 R4 R10 cfg"}, cfg_sel, exp_cfg);
  endtask

  task automatic run_data(input string tag);
    logic [N-1:0] pats [5] = '{8'hA5, 8'h5A, 8'hFF, 8'h01, 8'h80};
    loop_on = 1'b1;
    foreach (pats[p]) begin
      tx_data = pats[p];
      @(negedge clk);
      check(via_out == tx_expect(tx_data, exp_cfg), {tag, " R8 tx"},
            via_out, tx_expect(tx_data, exp_cfg));
      check((via_out & exp_map) == '0, {tag, " R8 broken low"}, via_out, '0);
      check(rx_data == tx_data, {tag, " R9 rx"}, rx_data, tx_data);
    end
    loop_on = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(cfg_sel == '0, "R1 cfg", cfg_sel, '0);
    check(!repair_done && !repair_ok, "R1 flags", {repair_done, repair_ok}, 0);
    tx_data = 8'hC3;
    @(negedge clk);
    check(via_out == {2'b00, 8'hC3}, "R1 identity tx", via_out, {2'b00, 8'hC3});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_solve(10'b0000000000, "R2 clear", '0, 1'b0);
    check(repair_ok == 1'b1 && cfg_sel == '0, "R2 identity", cfg_sel, '0);
    run_data("clear");
    run_solve(10'b0000000001, "via0 broken", '0, 1'b0);
    run_data("via0");
    run_solve(10'b0001001000, "two breaks", '0, 1'b0);
    run_data("two");
    run_solve(10'b1100000000, "top breaks", '0, 1'b0);
    run_data("top");
    run_solve(10'b0000011100, "R5 mid fail", '0, 1'b0);
    run_data("after fail");
    run_solve(10'b0000000111, "R5 low fail", '0, 1'b0);
    run_solve(10'b0000000011, "double shift", '0, 1'b0);
    run_data("double");
    run_solve(10'b0000100000, "R7 late load", 10'b0000000001, 1'b1);
    run_data("late");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule